// File: doc/BRIEF.md
# Debug Command Executor with Guard-Time Delay

This block executes command frames that a single-wire debug link has already received and parsed. For each frame it gets a command byte and a data byte, together with a strobe that marks the end of the master's frame. It supports three commands. One raises or drops a CPU halt request, and dropping the halt also fires a device reset pulse. One drives a vector of per-domain reset lines straight from the data byte. One selects the guard delay used before replies.

Every frame produces a one-byte reply: acknowledge or reject. The reply is not released as soon as the frame ends. The block counts bit-period ticks from the link's baud generator until the selected guard length has passed, then presents the reply for the transmitter to send. While it counts, the block reports busy and drops any new frame that arrives.

The halt request lets a debugger stop the CPU so that it cannot run a program that is only partly loaded while memory is being written.

Top module: `dbg_cmd_exec`

## Requirements
- R1: After reset, halt_o, dev_rst_o, busy_o and rsp_valid_o are 0, all dom_rst_o bits are 0 (released), and the guard setting selects 128 bit periods.
- R2: A frame with command 0x82 and data 0x01 sets halt_o to 1 from the cycle after the accepting clock edge, and its reply is 0x40.
- R3: A frame with command 0x82 and data 0x00 clears halt_o from the cycle after the accepting edge. One cycle later dev_rst_o goes high and stays high for exactly DEV_RST_CYC cycles. The reply is 0x40.
- R4: A frame with command 0x83 copies data bit i to dom_rst_o[i] for every domain i below N_DOM, where 1 holds the domain in reset and 0 releases it. Data bits at N_DOM and above are ignored. The reply is 0x40.
- R5: A frame with command 0x84 and data 0x00, 0x01, 0x02 or 0x03 sets the guard length to 128, 16, 4 or 1 bit ticks. The new length applies to replies of later frames, and the reply to this frame uses the previous length. The reply is 0x40.
- R6: A command byte other than 0x82, 0x83 or 0x84, a 0x82 frame with data other than 0x00 or 0x01, or a 0x84 frame with data above 0x03 changes no output state or setting, and its reply is 0x41.
- R7: After a frame is accepted, rsp_valid_o is high for exactly one cycle. That cycle is the one after the clock edge that samples the L-th bit_tick_i, where L is the guard length in force. A tick sampled in the same cycle as the frame is not counted. rsp_o holds the reply, which is 0x40 or 0x41.
- R8: busy_o is 1 from the cycle after acceptance until the cycle in which rsp_valid_o is high. A frame presented while busy_o is 1 is dropped: no state change and no reply of its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_valid_i | input | 1 | End-of-frame strobe; command and data bytes are valid |
| cmd_i | input | 8 | Command byte |
| data_i | input | 8 | Data byte |
| bit_tick_i | input | 1 | One pulse per link bit period |
| halt_o | output | 1 | CPU halt request |
| dev_rst_o | output | 1 | Device reset pulse issued on halt release |
| dom_rst_o | output | N_DOM | Per-domain reset lines, 1 = held in reset |
| busy_o | output | 1 | Guard delay running; new frames are dropped |
| rsp_valid_o | output | 1 | One-cycle strobe, reply byte ready for the transmitter |
| rsp_o | output | 8 | Reply byte, 0x40 acknowledge or 0x41 reject |

## Verification
A wrong guard setting or a wrong tick count shows up as rsp_valid_o arriving too early or too late, measured in ticks from the frame. Because the bench checks the tick just before the expected reply as well as the expected one, a count that is off by one fails within a single frame. A faulty decode shows up in the next cycle as a wrong halt_o or dom_rst_o value, or later as a wrong reply byte when rsp_valid_o rises. A busy flag that fails to drop frames shows up as reset lines that change after a frame sent mid-delay. A misplaced device-reset pulse is caught within DEV_RST_CYC+2 cycles of a halt release.

// File: rtl/dbg_exec_pkg.sv
package dbg_exec_pkg;
  localparam logic [7:0] CMD_HALT  = 8'h82;
  localparam logic [7:0] CMD_RESET = 8'h83;
  localparam logic [7:0] CMD_GUARD = 8'h84;
  localparam logic [7:0] RSP_ACK   = 8'h40;
  localparam logic [7:0] RSP_NAK   = 8'h41;

  typedef enum logic [1:0] {OP_NONE, OP_HALT, OP_RESET, OP_GUARD} op_e;

  typedef struct packed {
    op_e        op;
    logic       ok;
    logic [7:0] arg;
  } dec_t;

  function automatic logic [7:0] guard_len(input logic [1:0] code);
    case (code)
      2'd0:    return 8'd128;
      2'd1:    return 8'd16;
      2'd2:    return 8'd4;
      default: return 8'd1;
    endcase
  endfunction
endpackage

// File: rtl/dbg_cmd_decode.sv
module dbg_cmd_decode
  import dbg_exec_pkg::*;
(
  input  logic [7:0] cmd_i,
  input  logic [7:0] data_i,
  output dec_t       dec_o
);
  always_comb begin
    dec_o.arg = data_i;
    dec_o.op  = OP_NONE;
    dec_o.ok  = 1'b0;
    case (cmd_i)
      CMD_HALT: begin
        dec_o.op = OP_HALT;
        dec_o.ok = (data_i[7:1] == 7'd0);
      end
      CMD_RESET: begin
        dec_o.op = OP_RESET;
        dec_o.ok = 1'b1;
      end
      CMD_GUARD: begin
        dec_o.op = OP_GUARD;
        dec_o.ok = (data_i[7:2] == 6'd0);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dbg_guard_timer.sv
module dbg_guard_timer #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] len_i,
  input  logic          tick_i,
  output logic          busy_o,
  output logic          done_o
);
  logic [CW-1:0] cnt_q, len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      len_q  <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i && !busy_o) begin
        cnt_q  <= '0;
        len_q  <= len_i;
        busy_o <= 1'b1;
      end else if (busy_o && tick_i) begin
        if (cnt_q + CW'(1) == len_q) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end

  assert_done_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_busy_ends_in_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  assert_start_sets_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
endmodule

// File: rtl/dbg_rst_pulser.sv
module dbg_rst_pulser #(
  parameter int CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic pulse_o
);
  localparam int CNT_W = (CYC > 1) ? $clog2(CYC) : 1;
  logic             pend_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      pulse_o <= 1'b0;
      cnt_q   <= '0;
    end else begin
      pend_q <= fire_i;
      if (pend_q) begin
        pulse_o <= 1'b1;
        cnt_q   <= CNT_W'(CYC - 1);
      end else if (pulse_o) begin
        if (cnt_q == '0) pulse_o <= 1'b0;
        else             cnt_q   <= cnt_q - CNT_W'(1);
      end
    end
  end

  // pulse starts one cycle after the halt output has dropped
  assert_pulse_delay_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> ##1 pulse_o);
endmodule

// File: rtl/dbg_cmd_exec.sv
module dbg_cmd_exec
  import dbg_exec_pkg::*;
#(
  parameter int N_DOM       = 8,
  parameter int DEV_RST_CYC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_valid_i,
  input  logic [7:0]       cmd_i,
  input  logic [7:0]       data_i,
  input  logic             bit_tick_i,
  output logic             halt_o,
  output logic             dev_rst_o,
  output logic [N_DOM-1:0] dom_rst_o,
  output logic             busy_o,
  output logic             rsp_valid_o,
  output logic [7:0]       rsp_o
);
  localparam int CW = 8;

  dec_t       dec;
  logic       accept, fire;
  logic [1:0] code_q;

  dbg_cmd_decode u_dec (.cmd_i(cmd_i), .data_i(data_i), .dec_o(dec));

  assign accept = frame_valid_i && !busy_o;
  assign fire   = accept && dec.ok && (dec.op == OP_HALT) && !dec.arg[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_o <= 1'b0;
      code_q <= 2'd0;
      rsp_o  <= RSP_ACK;
    end else if (accept) begin
      rsp_o <= dec.ok ? RSP_ACK : RSP_NAK;
      if (dec.ok && dec.op == OP_HALT)  halt_o <= dec.arg[0];
      if (dec.ok && dec.op == OP_GUARD) code_q <= dec.arg[1:0];
    end
  end

  for (genvar i = 0; i < N_DOM; i++) begin : g_dom
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               dom_rst_o[i] <= 1'b0;
      else if (accept && dec.op == OP_RESET)     dom_rst_o[i] <= dec.arg[i];
    end
  end

  dbg_guard_timer #(.CW(CW)) u_guard (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(accept),
    .len_i(guard_len(code_q)), .tick_i(bit_tick_i),
    .busy_o(busy_o), .done_o(rsp_valid_o)
  );

  dbg_rst_pulser #(.CYC(DEV_RST_CYC)) u_pulse (
    .clk_i(clk_i), .rst_ni(rst_ni), .fire_i(fire), .pulse_o(dev_rst_o)
  );

  assert_rst_after_halt_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dev_rst_o) |-> !halt_o);
  assert_busy_drops_frame_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && frame_valid_i) |=> ($stable(halt_o) && $stable(dom_rst_o)));
  assert_reject_no_change_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !dec.ok) |=> ($stable(halt_o) && $stable(dom_rst_o)));
  assert_rsp_code_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_o == RSP_ACK || rsp_o == RSP_NAK));
endmodule

// File: tb/dbg_cmd_exec_test.sv
module dbg_cmd_exec_test;
  localparam int CLK_PERIOD = 10;
  localparam int N_DOM = 8;
  localparam int DEV_RST_CYC = 4;

  logic clk = 0, rst_ni = 0;
  logic frame_valid_i = 0, bit_tick_i = 0;
  logic [7:0] cmd_i = 0, data_i = 0;
  logic halt_o, dev_rst_o, busy_o, rsp_valid_o;
  logic [N_DOM-1:0] dom_rst_o;
  logic [7:0] rsp_o;

  int checks = 0, errors = 0, cycles = 0;
  logic exp_halt = 0;
  logic [N_DOM-1:0] exp_dom = '0;
  logic [1:0] exp_code = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_cmd_exec #(.N_DOM(N_DOM), .DEV_RST_CYC(DEV_RST_CYC)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .frame_valid_i(frame_valid_i),
    .cmd_i(cmd_i), .data_i(data_i), .bit_tick_i(bit_tick_i),
    .halt_o(halt_o), .dev_rst_o(dev_rst_o), .dom_rst_o(dom_rst_o),
    .busy_o(busy_o), .rsp_valid_o(rsp_valid_o), .rsp_o(rsp_o));

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int len_of(input logic [1:0] c);
    case (c) 2'd0: return 128; 2'd1: return 16; 2'd2: return 4; default: return 1; endcase
  endfunction

  function automatic logic valid_frame(input logic [7:0] c, input logic [7:0] d);
    if (c == 8'h82) return d <= 8'h01;
    if (c == 8'h83) return 1'b1;
    if (c == 8'h84) return d <= 8'h03;
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected <150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic send(input logic [7:0] c, input logic [7:0] d);
    @(negedge clk);
    frame_valid_i = 1; cmd_i = c; data_i = d;
    @(negedge clk);
    frame_valid_i = 0;
  endtask

  task automatic tick();
    int gap = $urandom_range(0, 2);
    repeat (gap) @(negedge clk);
    bit_tick_i = 1;
    @(negedge clk);
    bit_tick_i = 0;
  endtask

  // full frame: send, check state, optional mid-delay intrusion, wait reply
  task automatic frame(input logic [7:0] c, input logic [7:0] d, input logic intrude);
    logic ok = valid_frame(c, d);
    int L = len_of(exp_code);
    logic [7:0] exp_rsp = ok ? 8'h40 : 8'h41;
    logic was_release = 0;
    if (ok && c == 8'h82) begin exp_halt = d[0]; was_release = !d[0]; end
    if (ok && c == 8'h83) exp_dom = d[N_DOM-1:0];
    send(c, d);
    chk(busy_o == 1, "R8 busy after accept", busy_o, 1);
    chk(halt_o == exp_halt, ok ? "R2 halt state" : "R6 halt unchanged", halt_o, exp_halt);
    chk(dom_rst_o == exp_dom, ok ? "R4 domain resets" : "R6 domains unchanged", dom_rst_o, exp_dom);
    if (was_release) begin
      int hi = 0;
      chk(dev_rst_o == 0, "R3 no pulse while halt drops", dev_rst_o, 0);
      repeat (DEV_RST_CYC + 2) begin
        @(negedge clk);
        if (dev_rst_o) hi++;
      end
      chk(hi == DEV_RST_CYC, "R3 device reset width", hi, DEV_RST_CYC);
    end
    if (ok && c == 8'h84) exp_code = d[1:0];
    if (intrude && L > 1) begin
      send(8'h83, ~exp_dom);
      chk(dom_rst_o == exp_dom && busy_o == 1, "R8 frame dropped while busy", dom_rst_o, exp_dom);
    end
    for (int k = 1; k <= L; k++) begin
      tick();
      if (k == L - 1) chk(rsp_valid_o == 0, "R7 no early reply", rsp_valid_o, 0);
    end
    chk(rsp_valid_o == 1, "R7 reply on last tick", rsp_valid_o, 1);
    chk(rsp_o == exp_rsp, ok ? "R5 ack byte" : "R6 reject byte", rsp_o, exp_rsp);
    @(negedge clk);
    chk(rsp_valid_o == 0 && busy_o == 0, "R7 single-cycle reply, R8 busy clear", rsp_valid_o, 0);
    chk(dom_rst_o == exp_dom, "R8 no state change from dropped frame", dom_rst_o, exp_dom);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(halt_o == 0 && dev_rst_o == 0, "R1 halt and device reset idle", {halt_o, dev_rst_o}, 0);
    chk(dom_rst_o == '0, "R1 domains released", dom_rst_o, 0);
    chk(busy_o == 0 && rsp_valid_o == 0, "R1 not busy", {busy_o, rsp_valid_o}, 0);
    rst_ni = 1;
    @(negedge clk);
    // directed: first frame uses default length 128 (R1, R5)
    frame(8'h84, 8'h02, 0);   // R5 guard -> 4 after this reply
    frame(8'h82, 8'h01, 1);   // R2 halt
    frame(8'h83, 8'hA5, 1);   // R4
    frame(8'h82, 8'h02, 0);   // R6 bad halt data
    frame(8'h84, 8'h07, 0);   // R6 bad guard code
    frame(8'h55, 8'h00, 0);   // R6 unknown command
    frame(8'h82, 8'h00, 0);   // R3 release with device reset
    frame(8'h84, 8'h03, 0);   // R5 -> 1 tick
    frame(8'h83, 8'h3C, 0);
    frame(8'h84, 8'h01, 0);   // R5 -> 16
    frame(8'h83, 8'hFF, 1);
    frame(8'h84, 8'h00, 0);   // R5 -> 128
    frame(8'h83, 8'h00, 0);
    for (int i = 0; i < 50; i++) begin
      logic [7:0] c, d;
      case ($urandom_range(0, 5))
        0: begin c = 8'h82; d = 8'($urandom_range(0, 2)); end
        1, 2: begin c = 8'h83; d = 8'($urandom); end
        3: begin c = 8'h84; d = 8'($urandom_range(1, 4)); end
        4: begin c = 8'h84; d = 8'($urandom_range(2, 3)); end
        default: begin c = 8'($urandom); d = 8'($urandom); end
      endcase
      frame(c, d, 1'($urandom_range(0, 1)));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule